// File: doc/BRIEF.md
# Synchronous Serial Master with Receive Status

This block is an 8-bit serial master for SPI-style links. A byte written to its parallel transmit port is shifted out on `mosi`, most significant bit first. At the same time a byte is shifted in from `miso`. Both use a serial clock that the block derives from the system clock. Clock polarity and clock phase are chosen independently. A received byte lands in a one-entry receive buffer, which is read through a strobe.

Two sticky status flags sit next to the buffer. The overrun flag marks a byte that was lost because it was not read in time. The frame-error flag marks a transfer that was cut short by a bus conflict in four-pin mode. In that mode an external grant line must stay high while the master runs. If the line drops, the master stops, returns the clock to idle and keeps further loads out until the flag is cleared.

A software reset input returns the engine to idle and clears both flags. The system reset input `rst_n` does the same asynchronously.

Top module: `spi_sync_master`

## Requirements
- R1: A transfer has 8 serial clock periods, which makes 16 clock edges. It sends `tx_data` MSB first on `mosi`. It collects `miso` MSB first, and the resulting byte appears on `rx_data`.
- R2: While `tx_busy` is low, `sclk` rests at `cfg_cpol` (0 = low, 1 = high). One serial clock period lasts 2*`cfg_half` system clocks, and a `cfg_half` of 0 counts as 1. `tx_busy` stays high for exactly 16*`cfg_half` cycles, counted from the clock edge that accepts the load.
- R3: With `cfg_cpha`=1, `mosi` shows bit 7 of the loaded byte one clock after the load, which is before the first `sclk` edge. In this mode `miso` is sampled on the first edge of each bit and `mosi` changes on the second.
- R4: With `cfg_cpha`=0, `mosi` keeps the previous transfer's last bit until the first edge. In this mode `mosi` changes on the first edge of each bit and `miso` is sampled on the second.
- R5: `ovr_flag` is set in the following case. A new byte enters the receive buffer while the previous one is unread, meaning no `rx_rd` since it arrived. The old byte is overwritten.
- R6: `ovr_flag` is cleared by `rx_rd`, by `stat_clr[0]`, by `swrst` or by `rst_n`. If a new byte arrives in the same cycle as `rx_rd`, no overrun is recorded.
- R7: `tx_busy` falls on the clock of the last edge. One clock later `rx_ready` pulses high for exactly one cycle, and in that cycle `rx_data` already holds the new byte.
- R8: A `tx_load` while `tx_busy` is high is ignored. The running transfer continues with its original byte and no second transfer follows.
- R9: The conflict rule applies when `cfg_4pin`=1 and `bus_grant` is low while `tx_busy` is high.
  - On the next clock `frm_err` is set, `tx_busy` drops and `sclk` returns to idle.
  - No `rx_ready` follows and `rx_data` is unchanged.
  - While `frm_err` is set, `tx_load` is ignored.
  - `stat_clr[1]` or `swrst` clears `frm_err`.
- R10: `bus_grant` has no effect when `cfg_4pin`=0 or when no transfer is running.
- R11: `swrst` aborts any transfer on the next clock. It returns `sclk` to idle and clears `ovr_flag`, `frm_err` and the buffer's unread state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| swrst | input | 1 | Synchronous software reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase select (1 = first bit driven at load) |
| cfg_half | input | DIV_W | System clocks per serial clock half-period |
| cfg_4pin | input | 1 | Enables conflict detection on `bus_grant` |
| bus_grant | input | 1 | External bus enable; low while busy is a conflict in four-pin mode |
| tx_data | input | CHAR_BITS | Byte to transmit |
| tx_load | input | 1 | Starts a transfer of `tx_data` when idle |
| tx_busy | output | 1 | Transfer in progress |
| rx_data | output | CHAR_BITS | Receive buffer |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_ready | output | 1 | One-cycle pulse when a new byte enters the buffer |
| stat_clr | input | 2 | Bit 0 clears overrun, bit 1 clears frame error |
| ovr_flag | output | 1 | Overrun flag |
| frm_err | output | 1 | Frame-error flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Each output has a fixed time at which it is due:
- An accepted load shows on `tx_busy` and, in phase 1, on `mosi` at the very next clock.
- Each `sclk` edge comes `cfg_half` clocks after the previous one.
- `tx_busy` falls together with the sixteenth edge, and `rx_ready`, `rx_data` and `ovr_flag` follow one clock after that.
- Flag clears, conflicts and software resets take effect on the next clock.

The bench acts as a slave. It samples at the falling system clock edge and follows `sclk` edge by edge. It changes `miso` only on the edges where the master drives, and it reads `mosi` only on the edges where the master samples. Every result is read at the half cycle after the clock edge on which it is due.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Sticky status held beside the receive buffer.
    typedef struct packed {
        logic ovr;
        logic fe;
    } spim_flags_t;

    // Returns 1 when the edge selected by second_edge is the one on which
    // the master changes its output for the given phase setting.
    function automatic logic drive_on_edge(input logic cpha, input logic second_edge);
        return cpha ? second_edge : ~second_edge;
    endfunction

endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last  = (half == '0) ? '0 : half - ONE;
        tick  = run && (cnt_q == last);
        cnt_d = (!run || tick) ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (last != '0) |=> !tick); // R2

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic            tick,
    input  logic            cpha,
    input  logic [BITS-1:0] tx_data,
    input  logic            miso,
    output logic            busy,
    output logic            tog,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] word
);
    import spim_pkg::*;

    localparam int unsigned EDGES = 2 * BITS;
    localparam int unsigned EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);
    localparam logic [EW-1:0] E_ONE     = EW'(1);

    typedef struct packed {
        logic            busy;
        logic            tog;
        logic [EW-1:0]   edge_n;
        logic [BITS-1:0] txsh;
        logic [BITS-1:0] rxsh;
        logic            mosi;
        logic            done;
        logic [BITS-1:0] word;
    } eng_t;

    eng_t d, q;
    logic is_last;
    logic drive_now;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        is_last   = (q.edge_n == LAST_EDGE);
        drive_now = drive_on_edge(cpha, q.edge_n[0]);
        if (abort) begin
            d.busy   = 1'b0;
            d.tog    = 1'b0;
            d.edge_n = '0;
        end else if (start) begin
            d.busy   = 1'b1;
            d.tog    = 1'b0;
            d.edge_n = '0;
            d.rxsh   = '0;
            if (cpha) begin
                d.mosi = tx_data[BITS-1];
                d.txsh = {tx_data[BITS-2:0], 1'b0};
            end else begin
                d.txsh = tx_data;
            end
        end else if (q.busy && tick) begin
            d.tog    = ~q.tog;
            d.edge_n = q.edge_n + E_ONE;
            if (drive_now) begin
                if (!(cpha && is_last)) begin
                    d.mosi = q.txsh[BITS-1];
                    d.txsh = {q.txsh[BITS-2:0], 1'b0};
                end
            end else begin
                d.rxsh = {q.rxsh[BITS-2:0], miso};
            end
            if (is_last) begin
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.edge_n = '0;
                d.word   = drive_now ? q.rxsh : {q.rxsh[BITS-2:0], miso};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign tog  = q.tog;
    assign mosi = q.mosi;
    assign done = q.done;
    assign word = q.word;

    logic [BITS-1:0] txsh_q;
    assign txsh_q = q.txsh;

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick && !abort |=> $stable(txsh_q)); // R8
    AST_CPHA_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        start && !abort && cpha |=> mosi == $past(tx_data[BITS-1])); // R3
    AST_CPHA0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        start && !abort && !cpha |=> mosi == $past(mosi)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

endmodule

// File: rtl/spim_rxstat.sv
module spim_rxstat #(
    parameter int unsigned BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  swrst,
    input  logic                  done,
    input  logic [BITS-1:0]       word,
    input  logic                  rd,
    input  logic [1:0]            clr,
    input  logic                  conflict,
    output logic [BITS-1:0]       data,
    output logic                  ready,
    output spim_pkg::spim_flags_t flags
);
    import spim_pkg::*;

    typedef struct packed {
        logic [BITS-1:0] data;
        logic            full;
        logic            ready;
        spim_flags_t     flags;
    } rxs_t;

    rxs_t d, q;

    always_comb begin
        d       = q;
        d.ready = done;
        if (swrst) begin
            d.full  = 1'b0;
            d.ready = 1'b0;
            d.flags = '0;
        end else begin
            if (clr[0]) d.flags.ovr = 1'b0;
            if (clr[1]) d.flags.fe  = 1'b0;
            if (rd) begin
                d.full      = 1'b0;
                d.flags.ovr = 1'b0;
            end
            if (done) begin
                d.data = word;
                d.full = 1'b1;
                if (q.full && !rd) d.flags.ovr = 1'b1;
            end
            if (conflict) d.flags.fe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data  = q.data;
    assign ready = q.ready;
    assign flags = q.flags;

    logic full_q;
    assign full_q = q.full;

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done && full_q && !rd && !swrst |=> flags.ovr); // R5
    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !flags.ovr); // R6
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags.fe && !swrst && !clr[1] |=> flags.fe); // R9
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R7

endmodule

// File: rtl/spi_sync_master.sv
module spi_sync_master #(
    parameter int unsigned CHAR_BITS = 8,
    parameter int unsigned DIV_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 swrst,
    input  logic                 cfg_cpol,
    input  logic                 cfg_cpha,
    input  logic [DIV_W-1:0]     cfg_half,
    input  logic                 cfg_4pin,
    input  logic                 bus_grant,
    input  logic [CHAR_BITS-1:0] tx_data,
    input  logic                 tx_load,
    output logic                 tx_busy,
    output logic [CHAR_BITS-1:0] rx_data,
    input  logic                 rx_rd,
    output logic                 rx_ready,
    input  logic [1:0]           stat_clr,
    output logic                 ovr_flag,
    output logic                 frm_err,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso
);
    import spim_pkg::*;

    logic                 eng_busy, eng_tog, eng_done, tick;
    logic                 start, abort, conflict;
    logic [CHAR_BITS-1:0] eng_word;
    spim_flags_t          flags;

    assign conflict = cfg_4pin && !bus_grant && eng_busy;
    assign start    = tx_load && !eng_busy && !flags.fe && !swrst;
    assign abort    = swrst || conflict;

    spim_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .half (cfg_half),
        .tick (tick)
    );

    spim_shift #(.BITS(CHAR_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (abort),
        .tick   (tick),
        .cpha   (cfg_cpha),
        .tx_data(tx_data),
        .miso   (miso),
        .busy   (eng_busy),
        .tog    (eng_tog),
        .mosi   (mosi),
        .done   (eng_done),
        .word   (eng_word)
    );

    spim_rxstat #(.BITS(CHAR_BITS)) u_rxstat (
        .clk     (clk),
        .rst_n   (rst_n),
        .swrst   (swrst),
        .done    (eng_done),
        .word    (eng_word),
        .rd      (rx_rd),
        .clr     (stat_clr),
        .conflict(conflict),
        .data    (rx_data),
        .ready   (rx_ready),
        .flags   (flags)
    );

    assign tx_busy  = eng_busy;
    assign sclk     = cfg_cpol ^ eng_tog;
    assign ovr_flag = flags.ovr;
    assign frm_err  = flags.fe;

    AST_CONFLICT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        conflict && !swrst |=> !tx_busy && frm_err); // R9
    AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !tx_busy && !ovr_flag && !frm_err); // R11
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> sclk == cfg_cpol); // R2
    AST_GRANT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_4pin && !frm_err |=> !frm_err); // R10

endmodule

// File: tb/test_spi_sync_master.sv
module test_spi_sync_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       swrst = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_4pin = 1'b0, bus_grant = 1'b1;
    logic [7:0] cfg_half = 8'd2;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0, rx_rd = 1'b0, miso = 1'b0;
    logic [1:0] stat_clr = 2'b00;
    logic       tx_busy, rx_ready, ovr_flag, frm_err, sclk, mosi;
    logic [7:0] rx_data;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    spi_sync_master i_spi_sync_master (
        .clk(clk), .rst_n(rst_n), .swrst(swrst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_half(cfg_half), .cfg_4pin(cfg_4pin), .bus_grant(bus_grant), .tx_data(tx_data),
        .tx_load(tx_load), .tx_busy(tx_busy), .rx_data(rx_data), .rx_rd(rx_rd),
        .rx_ready(rx_ready), .stat_clr(stat_clr), .ovr_flag(ovr_flag), .frm_err(frm_err),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic int exp_busy_cycles(input logic [7:0] h);
        return 16 * ((h == 8'd0) ? 1 : int'(h));
    endfunction

    function automatic logic exp_first_mosi(input logic pha, input logic [7:0] tx, input logic prev);
        return pha ? tx[7] : prev;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_buf();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // Full transfer with the bench acting as slave. poke_at >= 0 raises a
    // second load once the given edge count is reached.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input logic pol,
                        input logic pha, input logic [7:0] h, input int poke_at);
        logic [7:0] got;
        int edges;
        int busy_cyc;
        logic prev;
        logic prev_mosi;
        bit poked;
        got = 8'h00; edges = 0; busy_cyc = 0; poked = 0;
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_half = h;
        tx_data = tx; tx_load = 1'b1; prev_mosi = mosi;
        if (pha) miso = sl[7];
        @(negedge clk);
        tx_load = 1'b0;
        check(mosi == exp_first_mosi(pha, tx, prev_mosi), pha ? "R3 first bit" : "R4 held bit",
              32'(mosi), 32'(exp_first_mosi(pha, tx, prev_mosi)));
        prev = pol;
        while (1) begin
            if (sclk !== prev) begin
                int k;
                k = edges;
                edges = edges + 1;
                prev = sclk;
                if (pha) begin
                    if (k % 2 == 1) begin
                        if ((k + 1) / 2 < 8) miso = sl[7 - (k + 1) / 2];
                    end else got = {got[6:0], mosi};
                end else begin
                    if (k % 2 == 0) miso = sl[7 - k / 2];
                    else got = {got[6:0], mosi};
                end
            end
            if (poke_at >= 0 && !poked && edges == poke_at) begin
                tx_data = ~tx; tx_load = 1'b1; poked = 1;
            end else tx_load = 1'b0;
            if (!tx_busy) break;
            busy_cyc = busy_cyc + 1;
            @(negedge clk);
        end
        tx_load = 1'b0;
        check(got == tx, "R1 mosi byte", 32'(got), 32'(tx));
        check(edges == 16, "R1 edge count", 32'(edges), 32'd16);
        check(busy_cyc == exp_busy_cycles(h), "R2 busy length", 32'(busy_cyc), 32'(exp_busy_cycles(h)));
        check(sclk == pol, "R2 idle level", 32'(sclk), 32'(pol));
        @(negedge clk);
        check(rx_ready == 1'b1, "R7 ready pulse", 32'(rx_ready), 32'd1);
        check(rx_data == sl, "R1 rx byte", 32'(rx_data), 32'(sl));
        @(negedge clk);
        check(rx_ready == 1'b0, "R7 ready one cycle", 32'(rx_ready), 32'd0);
        if (poke_at >= 0) check(tx_busy == 1'b0, "R8 load while busy ignored", 32'(tx_busy), 32'd0);
    endtask

    initial begin
        logic [7:0] held;
        int rdy_seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_busy == 1'b0, "R2 reset busy", 32'(tx_busy), 32'd0);
        check(sclk == 1'b0, "R2 reset sclk", 32'(sclk), 32'd0);
        check(ovr_flag == 1'b0 && frm_err == 1'b0, "R6 reset flags", 32'({ovr_flag, frm_err}), 32'd0);
        check(rx_ready == 1'b0, "R7 reset ready", 32'(rx_ready), 32'd0);

        // Directed: each polarity/phase pair, with the minimum and a zero half-period.
        xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 8'd1, -1); read_buf();
        xfer(8'h81, 8'h7E, 1'b1, 1'b0, 8'd2, -1); read_buf();
        xfer(8'h01, 8'hC3, 1'b0, 1'b1, 8'd3, -1); read_buf();
        xfer(8'hFE, 8'h18, 1'b1, 1'b1, 8'd0, -1); read_buf();

        // Random transfers, each read before the next.
        for (int i = 0; i < 24; i++) begin
            xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom_range(1, 4)), -1);
            read_buf();
            check(ovr_flag == 1'b0, "R5 no overrun after read", 32'(ovr_flag), 32'd0);
        end

        // R8: a load in the middle of a transfer.
        xfer(8'h5A, 8'h96, 1'b0, 1'b1, 8'd2, 5); read_buf();
        xfer(8'hC6, 8'h21, 1'b1, 1'b0, 8'd3, 9); read_buf();

        // R5/R6: overrun, then cleared by a read.
        xfer(8'h11, 8'h22, 1'b0, 1'b0, 8'd2, -1);
        check(ovr_flag == 1'b0, "R5 first byte no overrun", 32'(ovr_flag), 32'd0);
        xfer(8'h33, 8'h44, 1'b0, 1'b0, 8'd2, -1);
        check(ovr_flag == 1'b1, "R5 overrun set", 32'(ovr_flag), 32'd1);
        check(rx_data == 8'h44, "R5 old byte overwritten", 32'(rx_data), 32'h44);
        read_buf();
        check(ovr_flag == 1'b0, "R6 read clears overrun", 32'(ovr_flag), 32'd0);

        // R6: overrun cleared by an explicit clear.
        xfer(8'h55, 8'h66, 1'b1, 1'b1, 8'd1, -1);
        xfer(8'h77, 8'h88, 1'b1, 1'b1, 8'd1, -1);
        check(ovr_flag == 1'b1, "R5 overrun set again", 32'(ovr_flag), 32'd1);
        @(negedge clk); stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00;
        check(ovr_flag == 1'b0, "R6 clear bit 0", 32'(ovr_flag), 32'd0);
        read_buf();

        // R10: grant low is ignored in three-pin mode and while idle.
        bus_grant = 1'b0;
        xfer(8'h9C, 8'h3A, 1'b0, 1'b0, 8'd2, -1); read_buf();
        check(frm_err == 1'b0, "R10 grant ignored in 3-pin", 32'(frm_err), 32'd0);
        cfg_4pin = 1'b1;
        repeat (5) @(negedge clk);
        check(frm_err == 1'b0, "R10 grant ignored while idle", 32'(frm_err), 32'd0);
        bus_grant = 1'b1;

        // R9: conflict during a four-pin transfer.
        held = rx_data;
        @(negedge clk); cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_half = 8'd2; tx_data = 8'hE7; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        repeat (5) @(negedge clk);
        bus_grant = 1'b0;
        @(negedge clk);
        check(frm_err == 1'b1, "R9 frame error set", 32'(frm_err), 32'd1);
        check(tx_busy == 1'b0, "R9 master halted", 32'(tx_busy), 32'd0);
        check(sclk == 1'b1, "R9 clock idle", 32'(sclk), 32'd1);
        bus_grant = 1'b1;
        rdy_seen = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (rx_ready) rdy_seen = rdy_seen + 1;
        end
        check(rdy_seen == 0, "R9 no ready after halt", 32'(rdy_seen), 32'd0);
        check(rx_data == held, "R9 buffer unchanged", 32'(rx_data), 32'(held));
        tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        check(tx_busy == 1'b0, "R9 load ignored while flag set", 32'(tx_busy), 32'd0);
        stat_clr = 2'b10;
        @(negedge clk); stat_clr = 2'b00;
        check(frm_err == 1'b0, "R9 clear bit 1", 32'(frm_err), 32'd0);
        cfg_4pin = 1'b0;

        // R11: software reset in the middle of a transfer with overrun pending.
        xfer(8'h12, 8'h34, 1'b0, 1'b1, 8'd1, -1);
        xfer(8'h56, 8'h78, 1'b0, 1'b1, 8'd1, -1);
        @(negedge clk); cfg_cpol = 1'b1; tx_data = 8'hAA; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        repeat (6) @(negedge clk);
        swrst = 1'b1;
        @(negedge clk); swrst = 1'b0;
        check(tx_busy == 1'b0, "R11 idle after swrst", 32'(tx_busy), 32'd0);
        check(sclk == 1'b1, "R11 clock idle after swrst", 32'(sclk), 32'd1);
        check(ovr_flag == 1'b0 && frm_err == 1'b0, "R11 flags cleared", 32'({ovr_flag, frm_err}), 32'd0);
        rdy_seen = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (rx_ready) rdy_seen = rdy_seen + 1;
        end
        check(rdy_seen == 0, "R11 aborted byte not delivered", 32'(rdy_seen), 32'd0);
        // Unread state cleared: a new byte with no read raises no overrun.
        xfer(8'h0F, 8'hF0, 1'b1, 1'b0, 8'd2, -1);
        check(ovr_flag == 1'b0, "R11 unread state cleared", 32'(ovr_flag), 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule